// File: doc/BRIEF.md
# Outstanding Request Tracking Bridge

This block sits between a local memory-mapped bus and a packet link. Every request accepted on the bus becomes one outbound request descriptor. Reads, and writes that ask for a response, are recorded in two independent pending tables. Each entry is tagged with a 3-bit transaction ID from that table's own pool. Returning response descriptors are matched by table and ID. A busy response sends the request again under the same ID. A good read response supplies the read data. An error response or an expired per-entry timer completes the request with an error.

Read results reach the bus in the order the reads were accepted. A reorder buffer indexed by transaction ID holds results that arrive early. When a table has no free entry, the bus is held off with a wait-request output. Three counters track write traffic: writes accepted on the bus, write descriptors handed to the link side, and writes with response still in flight.

Top module: `orb_bridge`

## Requirements
- R1: Each accepted bus request produces exactly one new descriptor carrying its address, write data, write flag, write kind and ID. A descriptor stays stable while `dsc_valid` is high and `dsc_ready` is low. A read descriptor has `dsc_write`=0.
- R2: At most 8 reads may be outstanding. A ninth read is held with `bus_wait`=1 until the oldest read has been delivered on the bus. The read limit does not stall write requests.
- R3: Write kind 2 (`bus_wkind`=2'b10) needs a response and takes a pending-write entry, with at most 8 outstanding. Kind 0 (plain) and kind 1 (streaming) take no entry, are never stalled by that limit, and leave `cnt_wr_pend` unchanged.
- R4: A new tracked request gets the lowest free ID of its own table. The read and write ID pools are independent. Responses are matched on (`rsp_write`, `rsp_id`).
- R5: Response status 2'b00 (good) on a read makes the block pulse `rd_valid` for one cycle with `rd_data` equal to `rsp_data` and `rd_err`=0. The table entry is freed when the result is delivered.
- R6: Read results leave in acceptance order, whatever the order in which their responses arrive.
- R7: On status 2'b01 (busy), the same ID, address and data are sent again and the entry stays allocated. Re-sends take precedence over new bus requests.
- R8: On status 2'b10 or 2'b11 (error), a read completes with `rd_valid`=1 and `rd_err`=1, and a write frees its entry and pulses `wr_fail`.
- R9: Each entry's timer is loaded from `tmo_load` when its descriptor is issued. If it runs out before a response arrives, a read completes with `rd_err`=1. A write is instead freed, pulses `wr_fail` and decrements `cnt_wr_pend`.
- R10: A response whose ID is not awaiting an answer in its table is dropped and pulses `bad_rsp` for one cycle. It produces no read result and changes no counter.
- R11: `cnt_wr_acc` counts every accepted bus write. `cnt_wr_sent` counts every write descriptor taken, re-sends included. `cnt_wr_pend` rises on each accepted kind-2 write, falls on its completion or timeout, and never goes below zero.
- R12: After reset all counters are zero, and `bus_wait`, `dsc_valid`, `rd_valid`, `wr_fail` and `bad_rsp` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_load | input | TW | Timer value loaded when a descriptor is issued |
| bus_valid | input | 1 | Bus request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wkind | input | 2 | Write kind: 0 plain, 1 streaming, 2 with response |
| bus_addr | input | AW | Request address |
| bus_wdata | input | DW | Write data |
| bus_wait | output | 1 | Request not taken this cycle |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | DW | Read result data |
| rd_err | output | 1 | Read completed with error |
| wr_fail | output | 1 | Tracked write failed or timed out |
| dsc_valid | output | 1 | Outbound descriptor present |
| dsc_ready | input | 1 | Link side takes the descriptor |
| dsc_id | output | 3 | Transaction ID |
| dsc_write | output | 1 | Descriptor is a write |
| dsc_wkind | output | 2 | Write kind of the descriptor |
| dsc_addr | output | AW | Descriptor address |
| dsc_data | output | DW | Descriptor write data |
| rsp_valid | input | 1 | Response descriptor present |
| rsp_write | input | 1 | Response belongs to the write table |
| rsp_id | input | 3 | Response transaction ID |
| rsp_status | input | 2 | 0 good, 1 busy, 2 or 3 error |
| rsp_data | input | DW | Read response payload |
| bad_rsp | output | 1 | Unmatched response dropped |
| cnt_wr_acc | output | CW | Accepted bus writes |
| cnt_wr_sent | output | CW | Write descriptors handed over |
| cnt_wr_pend | output | CW | Writes with response in flight |

## Verification
The bench builds the block with its defaults: 8 entries per table, a 16-bit address, 32-bit data, a 12-bit timer and 16-bit counters. With 8 entries it can fill both tables, so it can show that the ninth read stalls while writes still pass, and that plain writes pass a full write table. The timer input is driven per test: a large value keeps normal traffic clear of timeouts, and values of 15 and 20 cycles expire a lone read or write inside a short window. A late response after such a timeout then becomes an unmatched response.

// File: rtl/orb_pkg.sv
package orb_pkg;

    typedef enum logic [1:0] {
        WK_PLAIN  = 2'd0,
        WK_STREAM = 2'd1,
        WK_RESP   = 2'd2,
        WK_SPARE  = 2'd3
    } wkind_e;

    typedef enum logic [1:0] {
        RS_OK   = 2'd0,
        RS_BUSY = 2'd1,
        RS_ERR  = 2'd2,
        RS_ERRX = 2'd3
    } rstat_e;

    function automatic logic is_tracked_write(input logic [1:0] kind);
        return wkind_e'(kind) == WK_RESP;
    endfunction

    function automatic logic is_fail(input logic [1:0] st);
        return (rstat_e'(st) == RS_ERR) || (rstat_e'(st) == RS_ERRX);
    endfunction

endpackage

// File: rtl/orb_pend_table.sv
module orb_pend_table #(
    parameter int NENT = 8,
    parameter int PW   = 16,
    parameter int TW   = 12,
    localparam int IW  = $clog2(NENT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   tmo_load,
    input  logic            alloc_en,
    input  logic [PW-1:0]   alloc_pl,
    output logic [IW-1:0]   free_id,
    output logic            full,
    input  logic            busy_en,
    input  logic            settle_en,
    input  logic            release_en,
    input  logic [IW-1:0]   rsp_id,
    input  logic [IW-1:0]   release_id,
    input  logic            reissue_en,
    output logic            rs_any,
    output logic [IW-1:0]   rs_id,
    output logic [PW-1:0]   rs_pl,
    input  logic            exp_block,
    output logic            exp_en,
    output logic [IW-1:0]   exp_id,
    output logic [NENT-1:0] vld_o,
    output logic [NENT-1:0] armed_o
);
    logic [NENT-1:0] vld, armed, rsd;
    logic [TW-1:0]   tmr [NENT];
    logic [PW-1:0]   pl  [NENT];

    // lowest-index search for free slot, pending re-send and expired timer
    always_comb begin
        free_id = '0;
        rs_id   = '0;
        exp_id  = '0;
        rs_any  = 1'b0;
        exp_en  = 1'b0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (!vld[i]) free_id = IW'(i);
            if (rsd[i]) begin
                rs_id  = IW'(i);
                rs_any = 1'b1;
            end
            if (armed[i] && tmr[i] == '0 && !exp_block) begin
                exp_id = IW'(i);
                exp_en = 1'b1;
            end
        end
    end

    assign full    = &vld;
    assign rs_pl   = pl[rs_id];
    assign vld_o   = vld;
    assign armed_o = armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= '0;
            armed <= '0;
            rsd   <= '0;
            for (int i = 0; i < NENT; i++) tmr[i] <= '0;
        end else begin
            for (int i = 0; i < NENT; i++) begin
                if (armed[i] && tmr[i] != '0) tmr[i] <= tmr[i] - 1'b1;
                if (exp_en && exp_id == IW'(i)) armed[i] <= 1'b0;
                if (settle_en && rsp_id == IW'(i)) armed[i] <= 1'b0;
                if (busy_en && rsp_id == IW'(i)) begin
                    armed[i] <= 1'b0;
                    rsd[i]   <= 1'b1;
                end
                if (reissue_en && rs_id == IW'(i)) begin
                    rsd[i]   <= 1'b0;
                    armed[i] <= 1'b1;
                    tmr[i]   <= tmo_load;
                end
                if (release_en && release_id == IW'(i)) begin
                    vld[i]   <= 1'b0;
                    armed[i] <= 1'b0;
                    rsd[i]   <= 1'b0;
                end
                if (alloc_en && free_id == IW'(i)) begin
                    vld[i]   <= 1'b1;
                    armed[i] <= 1'b1;
                    rsd[i]   <= 1'b0;
                    tmr[i]   <= tmo_load;
                    pl[i]    <= alloc_pl;
                end
            end
        end
    end

    // R2 / R3: an allocation never lands on an occupied entry
    a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !vld[free_id]);

    // R5: only occupied entries are released
    a_r5_release_valid: assert property (@(posedge clk) disable iff (rst)
        release_en |-> vld[release_id]);

endmodule

// File: rtl/orb_rd_reorder.sv
module orb_rd_reorder #(
    parameter int NENT = 8,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic [IW-1:0] push_id,
    input  logic          fill_en,
    input  logic [IW-1:0] fill_id,
    input  logic          fill_err,
    input  logic [DW-1:0] fill_data,
    output logic          pop_en,
    output logic [IW-1:0] pop_id,
    output logic [IW:0]   occ,
    output logic          out_valid,
    output logic          out_err,
    output logic [DW-1:0] out_data
);
    logic [IW-1:0]   ord [NENT];
    logic [IW-1:0]   hd, tl;
    logic [NENT-1:0] done, err_q;
    logic [DW-1:0]   dat [NENT];

    assign pop_id = ord[hd];
    assign pop_en = (occ != '0) && done[pop_id];

    always_ff @(posedge clk) begin
        if (rst) begin
            hd        <= '0;
            tl        <= '0;
            occ       <= '0;
            done      <= '0;
            err_q     <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pop_en;
            if (pop_en) begin
                out_data     <= dat[pop_id];
                out_err      <= err_q[pop_id];
                done[pop_id] <= 1'b0;
                hd           <= hd + 1'b1;
            end
            if (push_en) begin
                ord[tl] <= push_id;
                tl      <= tl + 1'b1;
            end
            occ <= occ + {{IW{1'b0}}, push_en} - {{IW{1'b0}}, pop_en};
            if (fill_en) begin
                done[fill_id]  <= 1'b1;
                err_q[fill_id] <= fill_err;
                dat[fill_id]   <= fill_data;
            end
        end
    end

    // R6: each read result is written once before it is delivered
    a_r6_fill_once: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !done[fill_id]);

endmodule

// File: rtl/orb_bridge.sv
module orb_bridge
    import orb_pkg::*;
#(
    parameter int NENT = 8,
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int TW   = 12,
    parameter int CW   = 16,
    localparam int IW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tmo_load,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [1:0]    bus_wkind,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_wait,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_err,
    output logic          wr_fail,
    output logic          dsc_valid,
    input  logic          dsc_ready,
    output logic [IW-1:0] dsc_id,
    output logic          dsc_write,
    output logic [1:0]    dsc_wkind,
    output logic [AW-1:0] dsc_addr,
    output logic [DW-1:0] dsc_data,
    input  logic          rsp_valid,
    input  logic          rsp_write,
    input  logic [IW-1:0] rsp_id,
    input  logic [1:0]    rsp_status,
    input  logic [DW-1:0] rsp_data,
    output logic          bad_rsp,
    output logic [CW-1:0] cnt_wr_acc,
    output logic [CW-1:0] cnt_wr_sent,
    output logic [CW-1:0] cnt_wr_pend
);
    localparam int WPW = AW + DW;

    logic            rd_full, wr_full, rd_rs_any, wr_rs_any, rd_exp, wr_exp;
    logic [IW-1:0]   rd_free, wr_free, rd_rs_id, wr_rs_id, rd_exp_id, wr_exp_id;
    logic [AW-1:0]   rd_rs_pl;
    logic [WPW-1:0]  wr_rs_pl;
    logic [NENT-1:0] rd_vld, rd_armed, wr_vld, wr_armed;
    logic            pop_en;
    logic [IW-1:0]   pop_id;
    logic [IW:0]     rd_occ;

    logic want_rd, want_wt, accept, rd_alloc, wr_alloc, rd_reissue, wr_reissue;
    logic rd_hit, wr_hit, rsp_busy, rd_busy, wr_busy, rd_settle, wr_done, wr_close;
    logic fill_en, fill_err;
    logic [IW-1:0] fill_id;

    assign want_rd  = bus_valid && !bus_write;
    assign want_wt  = bus_valid && bus_write && is_tracked_write(bus_wkind);
    assign bus_wait = dsc_valid || rd_rs_any || wr_rs_any
                   || (want_rd && rd_full) || (want_wt && wr_full);
    assign accept   = bus_valid && !bus_wait;
    assign rd_alloc = accept && !bus_write;
    assign wr_alloc = accept && bus_write && is_tracked_write(bus_wkind);

    assign rd_reissue = !dsc_valid && rd_rs_any;
    assign wr_reissue = !dsc_valid && !rd_rs_any && wr_rs_any;

    assign rd_hit    = rsp_valid && !rsp_write && rd_armed[rsp_id];
    assign wr_hit    = rsp_valid &&  rsp_write && wr_armed[rsp_id];
    assign rsp_busy  = rstat_e'(rsp_status) == RS_BUSY;
    assign rd_busy   = rd_hit && rsp_busy;
    assign wr_busy   = wr_hit && rsp_busy;
    assign rd_settle = rd_hit && !rsp_busy;
    assign wr_done   = wr_hit && !rsp_busy;
    assign wr_close  = wr_done || wr_exp;

    assign fill_en  = rd_settle || rd_exp;
    assign fill_id  = rd_settle ? rsp_id : rd_exp_id;
    assign fill_err = rd_settle ? (rstat_e'(rsp_status) != RS_OK) : 1'b1;

    orb_pend_table #(.NENT(NENT), .PW(AW), .TW(TW)) u_rd_tab (
        .clk, .rst, .tmo_load,
        .alloc_en(rd_alloc), .alloc_pl(bus_addr), .free_id(rd_free), .full(rd_full),
        .busy_en(rd_busy), .settle_en(rd_settle), .release_en(pop_en),
        .rsp_id, .release_id(pop_id),
        .reissue_en(rd_reissue), .rs_any(rd_rs_any), .rs_id(rd_rs_id), .rs_pl(rd_rs_pl),
        .exp_block(rsp_valid), .exp_en(rd_exp), .exp_id(rd_exp_id),
        .vld_o(rd_vld), .armed_o(rd_armed)
    );

    orb_pend_table #(.NENT(NENT), .PW(WPW), .TW(TW)) u_wr_tab (
        .clk, .rst, .tmo_load,
        .alloc_en(wr_alloc), .alloc_pl({bus_addr, bus_wdata}), .free_id(wr_free),
        .full(wr_full),
        .busy_en(wr_busy), .settle_en(1'b0), .release_en(wr_close),
        .rsp_id, .release_id(wr_done ? rsp_id : wr_exp_id),
        .reissue_en(wr_reissue), .rs_any(wr_rs_any), .rs_id(wr_rs_id), .rs_pl(wr_rs_pl),
        .exp_block(rsp_valid), .exp_en(wr_exp), .exp_id(wr_exp_id),
        .vld_o(wr_vld), .armed_o(wr_armed)
    );

    orb_rd_reorder #(.NENT(NENT), .DW(DW)) u_reorder (
        .clk, .rst,
        .push_en(rd_alloc), .push_id(rd_free),
        .fill_en, .fill_id, .fill_err, .fill_data(rsp_data),
        .pop_en, .pop_id, .occ(rd_occ),
        .out_valid(rd_valid), .out_err(rd_err), .out_data(rd_data)
    );

    // single outbound descriptor slot: re-sends first, then new bus requests
    always_ff @(posedge clk) begin
        if (rst) begin
            dsc_valid <= 1'b0;
            dsc_id    <= '0;
            dsc_write <= 1'b0;
            dsc_wkind <= '0;
            dsc_addr  <= '0;
            dsc_data  <= '0;
        end else if (dsc_valid) begin
            if (dsc_ready) dsc_valid <= 1'b0;
        end else if (rd_reissue) begin
            dsc_valid <= 1'b1;
            dsc_id    <= rd_rs_id;
            dsc_write <= 1'b0;
            dsc_wkind <= WK_PLAIN;
            dsc_addr  <= rd_rs_pl;
            dsc_data  <= '0;
        end else if (wr_reissue) begin
            dsc_valid <= 1'b1;
            dsc_id    <= wr_rs_id;
            dsc_write <= 1'b1;
            dsc_wkind <= WK_RESP;
            {dsc_addr, dsc_data} <= wr_rs_pl;
        end else if (accept) begin
            dsc_valid <= 1'b1;
            dsc_id    <= !bus_write ? rd_free : (wr_alloc ? wr_free : '0);
            dsc_write <= bus_write;
            dsc_wkind <= bus_write ? bus_wkind : WK_PLAIN;
            dsc_addr  <= bus_addr;
            dsc_data  <= bus_write ? bus_wdata : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_wr_acc  <= '0;
            cnt_wr_sent <= '0;
            cnt_wr_pend <= '0;
            bad_rsp     <= 1'b0;
            wr_fail     <= 1'b0;
        end else begin
            bad_rsp <= rsp_valid && !rd_hit && !wr_hit;
            wr_fail <= (wr_done && is_fail(rsp_status)) || wr_exp;
            if (accept && bus_write) cnt_wr_acc <= cnt_wr_acc + 1'b1;
            if (dsc_valid && dsc_ready && dsc_write) cnt_wr_sent <= cnt_wr_sent + 1'b1;
            if (wr_alloc && !wr_close)
                cnt_wr_pend <= cnt_wr_pend + 1'b1;
            else if (wr_close && !wr_alloc && cnt_wr_pend != '0)
                cnt_wr_pend <= cnt_wr_pend - 1'b1;
        end
    end

    // R1: a descriptor is held until the link side takes it
    a_r1_dsc_hold: assert property (@(posedge clk) disable iff (rst)
        dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_id) && $stable(dsc_addr)
                                   && $stable(dsc_data) && $stable(dsc_write));

    // R2 / R6: every occupied read entry has exactly one place in the delivery order
    a_r2_rd_occupancy: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_vld) == int'(rd_occ));

    // R11: the in-flight write counter follows the write table occupancy
    a_r11_pend_matches: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_wr_pend) == $countones(wr_vld));

    // R10: a drop flag only follows a presented response
    a_r10_bad_after_rsp: assert property (@(posedge clk) disable iff (rst)
        bad_rsp |-> $past(rsp_valid));

endmodule

// File: tb/orb_bridge_tb.sv
`timescale 1ns/1ps
module orb_bridge_tb_top;
    import orb_pkg::*;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TW = 12;
    localparam int CW = 16;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic [TW-1:0] tmo_load;
    logic          bus_valid, bus_write;
    logic [1:0]    bus_wkind;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wait, rd_valid, rd_err, wr_fail;
    logic [DW-1:0] rd_data;
    logic          dsc_valid, dsc_ready, dsc_write;
    logic [IW-1:0] dsc_id;
    logic [1:0]    dsc_wkind;
    logic [AW-1:0] dsc_addr;
    logic [DW-1:0] dsc_data;
    logic          rsp_valid, rsp_write;
    logic [IW-1:0] rsp_id;
    logic [1:0]    rsp_status;
    logic [DW-1:0] rsp_data;
    logic          bad_rsp;
    logic [CW-1:0] cnt_wr_acc, cnt_wr_sent, cnt_wr_pend;

    orb_bridge dut_i (
        .clk, .rst, .tmo_load, .bus_valid, .bus_write, .bus_wkind, .bus_addr, .bus_wdata,
        .bus_wait, .rd_valid, .rd_data, .rd_err, .wr_fail,
        .dsc_valid, .dsc_ready, .dsc_id, .dsc_write, .dsc_wkind, .dsc_addr, .dsc_data,
        .rsp_valid, .rsp_write, .rsp_id, .rsp_status, .rsp_data,
        .bad_rsp, .cnt_wr_acc, .cnt_wr_sent, .cnt_wr_pend
    );

    typedef struct packed {
        logic [IW-1:0] id;
        logic          wr;
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } dsc_t;

    int     vec = 0;
    int     bad = 0;
    int     badrsp_n = 0;
    int     wrfail_n = 0;
    logic [DW:0] exp_q[$];
    string  exp_tag[$];
    dsc_t   dq[$];

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: collects descriptors and pulses, compares read results
    always @(negedge clk) begin
        if (!rst) begin
            if (dsc_valid && dsc_ready)
                dq.push_back({dsc_id, dsc_write, dsc_wkind, dsc_addr, dsc_data});
            if (bad_rsp) badrsp_n++;
            if (wr_fail) wrfail_n++;
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R6", "unexpected read result", 64'(rd_valid), 64'(0));
                end else begin
                    automatic logic [DW:0] e = exp_q.pop_front();
                    automatic string t = exp_tag.pop_front();
                    check(t, "rd_err", 64'(rd_err), 64'(e[DW]));
                    if (!e[DW]) check(t, "rd_data", 64'(rd_data), 64'(e[DW-1:0]));
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_req(input logic wr, input logic [1:0] k,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_wkind = k; bus_addr = a; bus_wdata = d;
        #1;
        while (bus_wait) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    task automatic take_dsc(output dsc_t x);
        int n = 0;
        #1;
        while (dq.size() == 0 && n < 100) begin
            @(negedge clk);
            #2;
            n++;
        end
        if (dq.size() == 0) begin
            check("R1", "descriptor missing", 64'(0), 64'(1));
            x = '0;
        end else begin
            x = dq.pop_front();
        end
    endtask

    task automatic send_rsp(input logic wr, input logic [IW-1:0] id,
                            input logic [1:0] st, input logic [DW-1:0] d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_write = wr; rsp_id = id; rsp_status = st; rsp_data = d;
        @(posedge clk);
        #1;
        rsp_valid = 1'b0;
    endtask

    task automatic expect_rd(input logic err, input logic [DW-1:0] d, input string tag);
        exp_q.push_back({err, d});
        exp_tag.push_back(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        dsc_t d;
        int b0, f0;
        rst = 1'b1; tmo_load = 12'd1000; bus_valid = 1'b0; bus_write = 1'b0;
        bus_wkind = '0; bus_addr = '0; bus_wdata = '0; dsc_ready = 1'b1;
        rsp_valid = 1'b0; rsp_write = 1'b0; rsp_id = '0; rsp_status = '0; rsp_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R12: reset state
        check("R12", "bus_wait", 64'(bus_wait), 64'(0));
        check("R12", "dsc_valid", 64'(dsc_valid), 64'(0));
        check("R12", "rd_valid", 64'(rd_valid), 64'(0));
        check("R12", "flags", 64'({wr_fail, bad_rsp}), 64'(0));
        check("R12", "counters", 64'({cnt_wr_acc, cnt_wr_sent, cnt_wr_pend}), 64'(0));

        // R1 R4 R5: single read, good response
        bus_req(1'b0, 2'd0, 16'h0010, '0);
        take_dsc(d);
        check("R1", "read flag", 64'(d.wr), 64'(0));
        check("R1", "read addr", 64'(d.addr), 64'(16'h0010));
        check("R4", "first read id", 64'(d.id), 64'(0));
        expect_rd(1'b0, 32'hA1A1_0001, "R5");
        send_rsp(1'b0, d.id, 2'd0, 32'hA1A1_0001);
        idle(4);
        check("R5", "read delivered", 64'(exp_q.size()), 64'(0));

        // R6: responses out of order, results in order
        bus_req(1'b0, 2'd0, 16'h0020, '0);
        bus_req(1'b0, 2'd0, 16'h0030, '0);
        take_dsc(d);
        check("R4", "read id b", 64'(d.id), 64'(0));
        take_dsc(d);
        check("R4", "read id c", 64'(d.id), 64'(1));
        expect_rd(1'b0, 32'hB0B0_0002, "R6");
        expect_rd(1'b0, 32'hC0C0_0003, "R6");
        send_rsp(1'b0, 3'd1, 2'd0, 32'hC0C0_0003);
        idle(4);
        check("R6", "younger result held", 64'(exp_q.size()), 64'(2));
        send_rsp(1'b0, 3'd0, 2'd0, 32'hB0B0_0002);
        idle(5);
        check("R6", "both delivered", 64'(exp_q.size()), 64'(0));

        // R7: busy read re-sent with same id and address
        bus_req(1'b0, 2'd0, 16'h0040, '0);
        take_dsc(d);
        send_rsp(1'b0, d.id, 2'd1, '0);
        take_dsc(d);
        check("R7", "resend id", 64'(d.id), 64'(0));
        check("R7", "resend addr", 64'(d.addr), 64'(16'h0040));
        check("R7", "resend is read", 64'(d.wr), 64'(0));
        expect_rd(1'b0, 32'hD0D0_0004, "R7");
        send_rsp(1'b0, d.id, 2'd0, 32'hD0D0_0004);
        idle(5);

        // R8: read error response
        bus_req(1'b0, 2'd0, 16'h0050, '0);
        take_dsc(d);
        expect_rd(1'b1, '0, "R8");
        send_rsp(1'b0, d.id, 2'd2, 32'hFFFF_FFFF);
        idle(5);
        check("R8", "error delivered", 64'(exp_q.size()), 64'(0));

        // R9 R10: read timeout, then late response dropped
        tmo_load = 12'd20;
        bus_req(1'b0, 2'd0, 16'h0060, '0);
        take_dsc(d);
        expect_rd(1'b1, '0, "R9");
        idle(40);
        check("R9", "timeout delivered", 64'(exp_q.size()), 64'(0));
        tmo_load = 12'd1000;
        b0 = badrsp_n;
        send_rsp(1'b0, 3'd0, 2'd0, 32'h1234_5678);
        idle(4);
        check("R10", "late response flagged", 64'(badrsp_n - b0), 64'(1));

        // R10 R11: unknown ids on both tables
        b0 = badrsp_n;
        send_rsp(1'b0, 3'd5, 2'd0, 32'h0);
        send_rsp(1'b1, 3'd3, 2'd0, 32'h0);
        idle(3);
        check("R10", "unknown ids flagged", 64'(badrsp_n - b0), 64'(2));
        check("R11", "pending stays zero", 64'(cnt_wr_pend), 64'(0));

        // R3 R11: plain and streaming writes are untracked
        bus_req(1'b1, 2'd0, 16'h0070, 32'h7000_0000);
        bus_req(1'b1, 2'd1, 16'h0074, 32'h7400_0000);
        take_dsc(d);
        check("R1", "plain kind", 64'({d.wr, d.kind}), 64'({1'b1, 2'd0}));
        take_dsc(d);
        check("R1", "stream kind", 64'({d.wr, d.kind}), 64'({1'b1, 2'd1}));
        idle(3);
        check("R11", "acc after untracked", 64'(cnt_wr_acc), 64'(2));
        check("R11", "sent after untracked", 64'(cnt_wr_sent), 64'(2));
        check("R3", "untracked no pending", 64'(cnt_wr_pend), 64'(0));

        // R4 R11: write with response
        bus_req(1'b1, 2'd2, 16'h0080, 32'h8000_0001);
        take_dsc(d);
        check("R4", "write pool id", 64'(d.id), 64'(0));
        check("R1", "write data", 64'(d.data), 64'(32'h8000_0001));
        idle(2);
        check("R11", "pending up", 64'(cnt_wr_pend), 64'(1));
        f0 = wrfail_n;
        send_rsp(1'b1, d.id, 2'd0, '0);
        idle(3);
        check("R11", "pending down", 64'(cnt_wr_pend), 64'(0));
        check("R8", "good write no fail", 64'(wrfail_n - f0), 64'(0));

        // R7 R8: busy write re-sent, then error
        bus_req(1'b1, 2'd2, 16'h0084, 32'h8400_00AA);
        take_dsc(d);
        send_rsp(1'b1, d.id, 2'd1, '0);
        take_dsc(d);
        check("R7", "write resend", 64'({d.id, d.wr, d.kind, d.addr, d.data}),
              64'({3'd0, 1'b1, 2'd2, 16'h0084, 32'h8400_00AA}));
        f0 = wrfail_n;
        send_rsp(1'b1, d.id, 2'd3, '0);
        idle(3);
        check("R8", "write error flagged", 64'(wrfail_n - f0), 64'(1));
        check("R11", "sent with resend", 64'(cnt_wr_sent), 64'(5));

        // R2: eight reads fill the table, ninth stalls, writes still pass
        for (int i = 0; i < 8; i++) begin
            bus_req(1'b0, 2'd0, AW'(16'h0100 + i), '0);
            take_dsc(d);
            check("R4", "read id order", 64'(d.id), 64'(i));
        end
        idle(2);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 16'h0200;
        #1;
        check("R2", "ninth read stalled", 64'(bus_wait), 64'(1));
        bus_valid = 1'b0;
        bus_req(1'b1, 2'd2, 16'h0090, 32'h9000_0000);
        take_dsc(d);
        check("R2", "write passes full read table", 64'({d.wr, d.id}), 64'({1'b1, 3'd0}));
        expect_rd(1'b0, 32'h0000_0100, "R2");
        send_rsp(1'b0, 3'd0, 2'd0, 32'h0000_0100);
        bus_req(1'b0, 2'd0, 16'h0200, '0);
        take_dsc(d);
        check("R2", "ninth read gets freed id", 64'(d.id), 64'(0));
        for (int i = 1; i < 8; i++) begin
            expect_rd(1'b0, DW'(32'h0000_0100 + i), "R6");
            send_rsp(1'b0, IW'(i), 2'd0, DW'(32'h0000_0100 + i));
        end
        expect_rd(1'b0, 32'h0000_0200, "R6");
        send_rsp(1'b0, 3'd0, 2'd0, 32'h0000_0200);
        send_rsp(1'b1, 3'd0, 2'd0, '0);
        idle(5);
        check("R6", "read burst drained", 64'(exp_q.size()), 64'(0));

        // R3: eight tracked writes fill the write table
        for (int i = 0; i < 8; i++) begin
            bus_req(1'b1, 2'd2, AW'(16'h0300 + i), DW'(i));
            take_dsc(d);
            check("R4", "write id order", 64'(d.id), 64'(i));
        end
        idle(2);
        check("R3", "pending at limit", 64'(cnt_wr_pend), 64'(8));
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wkind = 2'd2; bus_addr = 16'h0400;
        #1;
        check("R3", "ninth tracked write stalled", 64'(bus_wait), 64'(1));
        bus_wkind = 2'd0;
        #1;
        check("R3", "plain write not stalled", 64'(bus_wait), 64'(0));
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        take_dsc(d);
        check("R3", "plain write kind", 64'(d.kind), 64'(0));
        idle(2);
        check("R3", "pending unchanged by plain", 64'(cnt_wr_pend), 64'(8));
        for (int i = 0; i < 8; i++) send_rsp(1'b1, IW'(i), 2'd0, '0);
        idle(3);
        check("R11", "pending drained", 64'(cnt_wr_pend), 64'(0));

        // R9: tracked write times out
        tmo_load = 12'd15;
        f0 = wrfail_n;
        bus_req(1'b1, 2'd2, 16'h0500, 32'h5000_0000);
        take_dsc(d);
        idle(2);
        check("R9", "pending before timeout", 64'(cnt_wr_pend), 64'(1));
        idle(30);
        check("R9", "pending after timeout", 64'(cnt_wr_pend), 64'(0));
        check("R9", "timeout flagged", 64'(wrfail_n - f0), 64'(1));

        // R11: final counters, R1: no stray descriptors
        check("R11", "final accepted", 64'(cnt_wr_acc), 64'(15));
        check("R11", "final sent", 64'(cnt_wr_sent), 64'(16));
        check("R1", "no extra descriptors", 64'(dq.size()), 64'(0));

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule